// File: doc/BRIEF.md
# Byte-Register GPIO Expander with Change Interrupts

This block turns a set of eight pads into host-controlled general-purpose pins. A host with a simple byte-wide register port chooses, for each pin, whether it drives or listens. It sets the level each driving pin produces, and it selects a pull resistor for each listening pin. It can also arm a change interrupt per pin. Raw pad levels pass through a synchronizer before they are used. A single value register reads back what every pin is doing. For listening pins that is the synchronized pad level, and for driving pins it is the held output value.

When an armed listening pin changes level, in either direction, its bit in a sticky status register is set. In the same cycle the block sends a one-cycle set pulse on bit 5 of an 8-bit vector. The main interrupt-status logic ORs that vector into its own register. Status bits stay set until the host writes them back to zero.

Top module: `gpio_expander`

## Requirements
- R1: After reset the registers read as follows: direction (0x0B) 0xFF, pull enable (0x0C) 0x00, pull direction (0x0D) 0xFF, interrupt enable (0x0F) 0x00, interrupt status (0x10) 0x00, held output value 0x00. `pad_oe`, `pad_out`, `pad_pu` and `pad_pd` are all 0.
- R2: A direction bit of 1 makes the pin an input (`pad_oe` bit 0). A bit of 0 makes it an output (`pad_oe` bit 1), and then `pad_out` carries the held output value for that pin. `pad_out` is 0 on input pins.
- R3: `pad_pu` = input & pull-enable & pull-direction, and `pad_pd` = input & pull-enable & ~pull-direction (pull-direction 1 = up, 0 = down). Output pins never get a pull.
- R4: A write to the value register (0x0E) changes the held output value only at output pins. The held value of a pin survives a switch to input and back, so it reappears on `pad_out`.
- R5: A read of 0x0E returns, per pin, the synchronized pad level for inputs and the held output value for outputs. A pad change becomes visible after the second rising clock edge following it.
- R6: A level change in either direction on an input pin whose interrupt-enable bit is 1 sets that pin's status bit at the third rising edge after the pad change.
- R7: Pins configured as outputs, and input pins with the enable bit at 0, never set a status bit.
- R8: Reading the status register does not clear it. A write to 0x10 clears the bits written as 0 and cannot set any bit.
- R9: When a new change on pin k and a status write that clears bit k take effect at the same edge, bit k ends up set (set wins over clear).
- R10: `main_int_set` bit 5 is high for exactly the one cycle after the edge at which any status bit is triggered. All other bits of `main_int_set` are always 0.
- R11: A pad pulse that begins and ends between two rising clock edges is never seen: no status bit and no change in the read value.
- R12: Reads of any address other than 0x0B to 0x10 return 0x00. Writes to such addresses change no register or pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one byte per cycle |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pad_in | input | 8 | Raw pad levels, asynchronous |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pad_pd | output | 8 | Per-pin pull-down enable |
| main_int_set | output | 8 | Set pulses for the main interrupt-status register (bit 5 used) |

## Verification
A pin's change trigger and the host's clearing write to the status register can take effect at the same edge. The bench provokes this by toggling pad bit 2 at a falling edge and then holding a write of 0x00 to 0x10 across the third rising edge that follows. Status bit 1 was set earlier and must be cleared. The check expects the status register to read exactly 0x04 afterwards, and `main_int_set` to show 0x20 in that cycle. Constrained random writes to every register are also interleaved with pad changes. These compare every register and pad output against a bench model of the register file.

// File: rtl/gpx_pkg.sv
// Package: shared constants for the GPIO expander.
// Assumes an 8-bit register address space decoded by the host.
package gpx_pkg;
    localparam logic [7:0] ADDR_DIR = 8'h0B;  // 1 = input, 0 = output
    localparam logic [7:0] ADDR_PEN = 8'h0C;  // pull enable
    localparam logic [7:0] ADDR_PSEL = 8'h0D; // pull select, 1 = up
    localparam logic [7:0] ADDR_VAL = 8'h0E;  // pin value
    localparam logic [7:0] ADDR_IEN = 8'h0F;  // change interrupt enable
    localparam logic [7:0] ADDR_IST = 8'h10;  // change interrupt status
endpackage

// File: rtl/gpx_sync.sv
// Module: gpx_sync
// Multi-stage flop synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is sampled independently; no bus coherency is implied.
module gpx_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // First stage captures the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-samples the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpx_cfg.sv
// Module: gpx_cfg
// Configuration registers and pad control: direction, pull enable, pull
// select, interrupt enable and the held output value.
// Assumes the caller decodes nothing; this module decodes its own addresses.
module gpx_cfg
    import gpx_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] pen_q,
    output logic [NPINS-1:0] psel_q,
    output logic [NPINS-1:0] ien_q,
    output logic [NPINS-1:0] hold_q,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pu,
    output logic [NPINS-1:0] pad_pd
);
    // Direction register, all inputs after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                       dir_q <= '1;
        else if (wr && addr == ADDR_DIR)  dir_q <= wdata;
    end

    // Pull enable register, pulls off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pen_q <= '0;
        else if (wr && addr == ADDR_PEN)  pen_q <= wdata;
    end

    // Pull select register, pull-up after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                       psel_q <= '1;
        else if (wr && addr == ADDR_PSEL) psel_q <= wdata;
    end

    // Change interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ien_q <= '0;
        else if (wr && addr == ADDR_IEN)  ien_q <= wdata;
    end

    // Held output value: only output pins take new data, inputs keep theirs.
    always_ff @(posedge clk) begin
        if (!rst_n)                      hold_q <= '0;
        else if (wr && addr == ADDR_VAL) hold_q <= (hold_q & dir_q) | (wdata & ~dir_q);
    end

    // Pad controls derived from the configuration.
    always_comb begin
        pad_oe  = ~dir_q;
        pad_out = hold_q & ~dir_q;
        pad_pu  = dir_q & pen_q & psel_q;
        pad_pd  = dir_q & pen_q & ~psel_q;
    end
endmodule

// File: rtl/gpx_irq.sv
// Module: gpx_irq
// Change detection on synchronized input levels, sticky per-pin status and
// a one-cycle event pulse. Set wins over a clearing write at the same edge.
// Assumes lvl is already synchronous to clk.
module gpx_irq #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] ien_q,
    input  logic             st_wr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] ist_q,
    output logic             event_q
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] trig;
    logic [NPINS-1:0] ist_d;

    // Previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Trigger on any level change of an armed input pin; next status value.
    always_comb begin
        trig  = (lvl ^ prev_q) & dir_q & ien_q;
        ist_d = (st_wr ? (wdata & ist_q) : ist_q) | trig;
    end

    // Sticky status and event pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ist_q   <= '0;
            event_q <= 1'b0;
        end else begin
            ist_q   <= ist_d;
            event_q <= |trig;
        end
    end
endmodule

// File: rtl/gpio_expander.sv
// Module: gpio_expander (top)
// Eight-pin GPIO expander on a byte register port, with synchronized inputs,
// pad pull control and sticky change interrupts. Raises a set pulse on a
// chosen bit of the main interrupt-status vector.
// Assumes reg_rdata is sampled by the host in the cycle reg_addr is valid.
module gpio_expander
    import gpx_pkg::*;
#(
    parameter int NPINS      = 8,
    parameter int SYNC_STG   = 2,
    parameter int MAIN_W     = 8,
    parameter int MAIN_BIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd,
    output logic [MAIN_W-1:0] main_int_set
);
    logic [NPINS-1:0] dir_q, pen_q, psel_q, ien_q, hold_q;
    logic [NPINS-1:0] lvl, ist_q;
    logic             event_q;

    gpx_sync #(.W(NPINS), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (lvl)
    );

    gpx_cfg #(.NPINS(NPINS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .dir_q   (dir_q),
        .pen_q   (pen_q),
        .psel_q  (psel_q),
        .ien_q   (ien_q),
        .hold_q  (hold_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .pad_pu  (pad_pu),
        .pad_pd  (pad_pd)
    );

    gpx_irq #(.NPINS(NPINS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .dir_q   (dir_q),
        .ien_q   (ien_q),
        .st_wr   (reg_wr && reg_addr == ADDR_IST),
        .wdata   (reg_wdata),
        .ist_q   (ist_q),
        .event_q (event_q)
    );

    // Read multiplexer; the value register mixes inputs and held outputs.
    always_comb begin
        unique case (reg_addr)
            ADDR_DIR:  reg_rdata = dir_q;
            ADDR_PEN:  reg_rdata = pen_q;
            ADDR_PSEL: reg_rdata = psel_q;
            ADDR_VAL:  reg_rdata = (dir_q & lvl) | (~dir_q & hold_q);
            ADDR_IEN:  reg_rdata = ien_q;
            ADDR_IST:  reg_rdata = ist_q;
            default:   reg_rdata = '0;
        endcase
    end

    // Place the event pulse on its bit of the main interrupt vector.
    for (genvar b = 0; b < MAIN_W; b++) begin : g_main
        if (b == MAIN_BIT) begin : g_hit
            assign main_int_set[b] = event_q;
        end else begin : g_zero
            assign main_int_set[b] = 1'b0;
        end
    end
endmodule

// File: rtl/gpx_checker.sv
// Module: gpx_checker
// Property checks for gpio_expander, attached by bind below.
module gpx_checker #(
    parameter int NPINS  = 8,
    parameter int MAIN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [7:0]        reg_addr,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_pu,
    input logic [NPINS-1:0]  pad_pd,
    input logic [MAIN_W-1:0] main_int_set,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  ien_q,
    input logic [NPINS-1:0]  ist_q
);
    // R3: never both pulls, never a pull on a driving pin
    a_r3_pull_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_pd) == '0) && (((pad_pu | pad_pd) & pad_oe) == '0));

    // R2: no high level is presented on a pin that is not driven
    a_r2_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R7: a newly set status bit had its pin armed as input in the prior cycle
    a_r7_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((ist_q & ~$past(ist_q)) & ~$past(dir_q & ien_q)) == '0);

    // R8: without a status write, status bits never fall
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 8'h10) |=> ((ist_q & $past(ist_q)) == $past(ist_q)));

    // R10: a newly set status bit comes with the main pulse
    a_r10_pulse_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((ist_q & ~$past(ist_q)) != '0) |-> main_int_set[5]);

    // R10: only bit 5 of the main vector is ever used
    a_r10_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(main_int_set) <= 1 && (main_int_set & ~(MAIN_W'(1) << 5)) == '0);
endmodule

bind gpio_expander gpx_checker #(.NPINS(NPINS), .MAIN_W(MAIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out),
    .pad_pu       (pad_pu),
    .pad_pd       (pad_pd),
    .main_int_set (main_int_set),
    .dir_q        (dir_q),
    .ien_q        (ien_q),
    .ist_q        (ist_q)
);

// File: tb/gpio_expander_tb.sv
`timescale 1ns/1ps
module gpio_expander_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out, pad_pu, pad_pd, main_int_set;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // model state
    logic [7:0] m_dir = 8'hFF, m_pen = 8'h00, m_psel = 8'hFF, m_ien = 8'h00;
    logic [7:0] m_ist = 8'h00, m_hold = 8'h00, pads = 8'h00;

    always #5 clk = ~clk;

    gpio_expander u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .main_int_set(main_int_set)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h0B: return m_dir;
            8'h0C: return m_pen;
            8'h0D: return m_psel;
            8'h0E: return (m_dir & pads) | (~m_dir & m_hold);
            8'h0F: return m_ien;
            8'h10: return m_ist;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            8'h0B: m_dir = d;
            8'h0C: m_pen = d;
            8'h0D: m_psel = d;
            8'h0E: m_hold = (m_hold & m_dir) | (d & ~m_dir);
            8'h0F: m_ien = d;
            8'h10: m_ist = d & m_ist;
            default: ;
        endcase
    endtask

    task automatic set_pads(input logic [7:0] v);
        @(negedge clk);
        m_ist = m_ist | ((pads ^ v) & m_dir & m_ien);
        pads = v;
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int a = 8'h0B; a <= 8'h10; a++) begin
            rd(8'(a), v);
            chk(req, v, exp_read(8'(a)));
        end
        chk(req, pad_oe, ~m_dir);
        chk(req, pad_out, m_hold & ~m_dir);
        chk(req, pad_pu, m_dir & m_pen & m_psel);
        chk(req, pad_pd, m_dir & m_pen & ~m_psel);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_all("R1");
        chk("R1 main", main_int_set, 8'h00);

        // R2 direction and driven value
        wr(8'h0B, 8'h0F);
        wr(8'h0E, 8'hA5);
        check_all("R2");
        chk("R2 pad_out", pad_out, 8'hA0);

        // R3 pulls only on inputs
        wr(8'h0C, 8'hFF);
        wr(8'h0D, 8'h3C);
        check_all("R3");
        chk("R3 pu", pad_pu, 8'h0C);
        chk("R3 pd", pad_pd, 8'h03);

        // R4 held value survives direction round trip
        wr(8'h0B, 8'hFF);
        chk("R4 released", pad_out, 8'h00);
        wr(8'h0B, 8'h0F);
        chk("R4 restored", pad_out, 8'hA0);
        check_all("R4");

        // R5 readback mix and two-edge latency
        @(negedge clk);
        pad_in = 8'h5A;
        @(posedge clk); @(negedge clk);
        rd(8'h0E, v); chk("R5 one edge", v, 8'hA0);
        @(posedge clk); @(negedge clk);
        rd(8'h0E, v); chk("R5 two edges", v, 8'hAA);
        pads = 8'h5A;
        repeat (2) @(negedge clk);
        check_all("R5");

        // R6 and R10: armed input change, status and pulse timing
        wr(8'h0F, 8'h0F);
        @(negedge clk);
        pads = pads ^ 8'h01; pad_in = pads;
        @(negedge clk); chk("R10 e1", main_int_set, 8'h00);
        @(negedge clk); chk("R10 e2", main_int_set, 8'h00);
        rd(8'h10, v);   chk("R6 before e3", v, 8'h00);
        @(negedge clk); chk("R10 e3", main_int_set, 8'h20);
        rd(8'h10, v);   chk("R6 at e3", v, 8'h01);
        @(negedge clk); chk("R10 e4", main_int_set, 8'h00);
        m_ist = 8'h01;
        check_all("R6");

        // R7: output pins and disarmed inputs never trigger
        wr(8'h0F, 8'hFE);
        set_pads(pads ^ 8'hF1);
        check_all("R7");
        chk("R7 none", m_ist, 8'h01);

        // R8: read does not clear, writing ones cannot set, zeros clear
        rd(8'h10, v); rd(8'h10, v);
        chk("R8 read twice", v, 8'h01);
        wr(8'h10, 8'hFF);
        check_all("R8 ones");
        wr(8'h10, 8'h00);
        check_all("R8 clear");

        // R9: set at the same edge as a clearing write
        set_pads(pads ^ 8'h02);
        chk("R9 pre", m_ist, 8'h02);
        @(negedge clk);
        pads = pads ^ 8'h04; pad_in = pads;
        @(negedge clk); @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 8'h00;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R9 main", main_int_set, 8'h20);
        m_ist = 8'h04;
        rd(8'h10, v); chk("R9 status", v, 8'h04);
        check_all("R9");

        // R11: glitch between edges is invisible
        wr(8'h10, 8'h00);
        @(negedge clk);
        pad_in = pads ^ 8'h08;
        #2 pad_in = pads;
        repeat (4) @(negedge clk);
        check_all("R11");

        // R12: unmapped addresses
        for (int a = 0; a < 8'h0B; a++) begin
            rd(8'(a), v); chk("R12 read", v, 8'h00);
        end
        rd(8'h11, v); chk("R12 read hi", v, 8'h00);
        wr(8'h05, 8'h00); wr(8'h11, 8'hFF); wr(8'h8E, 8'hFF);
        check_all("R12");

        // random phase covering R2..R8
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            if (op < 4) begin
                set_pads(8'($urandom));
            end else if (op < 8) begin
                wr(8'(8'h0B + $urandom_range(0, 5)), 8'($urandom));
            end else begin
                wr(8'($urandom_range(0, 31)), 8'($urandom));
            end
            check_all("R4/R5/R6/R8 random");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule